// File: doc/BRIEF.md
# Keyboard Scan Code Translator

This block sits between a serial keyboard receiver and a terminal that expects an older parallel keyboard. Each key event arrives as an 8-bit position code with a press/release flag on a valid/ready handshake. A 128-entry lookup table turns each position into a 7-bit target code. A filter then decides, event by event, whether to send the target code, send the release code, or send nothing. Codes that are sent wait in a small queue until the terminal takes them.

The filter has three special rules. Keys with a single target code send only on press, and their releases are dropped. The Alt key is tracked as held or not held. Its press and its release each send one code, so an Alt chord appears at the terminal as Alt press, the chorded key, then Alt release, and repeated Alt presses are ignored. The Enter key sends once per run of presses: repeated Enter presses from an auto-repeating keyboard are dropped until an event for another mapped key arrives.

On the terminal side, an output state machine walks through Idle, Show and Gap. In Idle it loads the next queued code and moves to Show when the queue is not empty and acknowledge is low. In Show it presents the code with the strobe high and moves to Gap when acknowledge rises. In Gap it keeps the strobe low and returns to Idle when acknowledge falls. The filter has two states, Alt-up and Alt-down: an accepted Alt press moves it from Alt-up to Alt-down, and an accepted Alt release moves it back. Four identifier bits are driven from a parameter.

Top module: `kbx_translator`

## Requirements
- R1: After a synchronous reset (`rst` high on a clock edge), `kb_avail` is low and `ev_ready` is high.
- R2: `kb_ident` always equals the parameter IDENT (default 4'b1010).
- R3: Input code c in 0x01..0x6F has a table entry. Its press code is c XOR 0x55. On press, that code is presented with `kb_make`=1.
- R4: A key without a release code sends nothing on release. Only positions 0x20..0x3F and the Alt key have a release code.
- R5: On release of a key that has a release code, the code c XOR 0x2A is presented with `kb_make`=0.
- R6: Input codes 0x00, 0x70..0x7F and any code with bit 7 set are discarded and produce no output.
- R7: The Alt key (default 0x11) sends its press code only when Alt is not held, and its release code (0x3B) only when Alt is held. Other keys pass between these two codes unchanged, so a chord gives Alt press, key, Alt release.
- R8: The Enter key (default 0x5A) sends press code 0x0F only when not blocked, and every Enter press sets the block. Any event for another mapped key clears the block. Unmapped codes leave it as it is. Enter release sends nothing.
- R9: While `kb_avail` is high and `kb_ack` is low, `kb_avail`, `kb_code` and `kb_make` hold steady.
- R10: After `kb_ack` is seen high, `kb_avail` is low in the next cycle. No new code is presented until `kb_ack` has returned low.
- R11: Codes leave in the order they were produced. `ev_ready` is low while the queue (FIFO_DEPTH, default 4) is full, and no code is lost.
- R12: Reset clears pending codes, the Alt held state and the Enter block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | Key event valid |
| ev_ready | output | 1 | Event accepted when high with ev_valid |
| ev_code | input | 8 | Key position code |
| ev_make | input | 1 | 1 = press, 0 = release |
| kb_code | output | 7 | Parallel scan code to terminal |
| kb_make | output | 1 | 1 = press code, 0 = release code |
| kb_avail | output | 1 | Data-available strobe |
| kb_ack | input | 1 | Acknowledge from terminal |
| kb_ident | output | 4 | Static keyboard variant identifier |

## Verification
The embedded properties check the terminal handshake on every cycle: the code and strobe hold until acknowledge, the strobe falls right after acknowledge and stays low while acknowledge is high, and the queue never overflows or underflows. The code-level rules can only be shown by the bench scenarios, because they depend on sequences of events: which releases are dropped, which codes are unmapped, the Alt pairing, the Enter blocking and its clearing, the order of codes under backpressure, and the clearing of state by reset. The scoreboard compares every presented code with its expectation. The dropped events are confirmed by the next expected code arriving with nothing before it.

// File: rtl/kbx_pkg.sv
package kbx_pkg;
    localparam int IN_W  = 8;
    localparam int OUT_W = 7;
    localparam int ID_W  = 4;

    typedef struct packed {
        logic             valid;
        logic             has_brk;
        logic [OUT_W-1:0] mk;
        logic [OUT_W-1:0] bk;
    } kbx_ent_t;

    typedef struct packed {
        logic             make;
        logic [OUT_W-1:0] code;
    } kbx_out_t;

    typedef enum logic [1:0] {O_IDLE, O_SHOW, O_GAP} kbx_ost_t;
    typedef enum logic {F_ALT_UP, F_ALT_DOWN} kbx_fst_t;

    function automatic kbx_ent_t kbx_entry(input logic [OUT_W-1:0] k,
                                           input logic [OUT_W-1:0] alt);
        kbx_ent_t e;
        e.valid   = (k != '0) && (k[6:4] != 3'b111);
        e.has_brk = e.valid && ((k[6:5] == 2'b01) || (k == alt));
        e.mk      = k ^ 7'h55;
        e.bk      = k ^ 7'h2A;
        return e;
    endfunction
endpackage

// File: rtl/kbx_map.sv
module kbx_map #(
    parameter logic [kbx_pkg::OUT_W-1:0] ALT_IDX = 7'h11
) (
    input  logic [kbx_pkg::OUT_W-1:0] key,
    output kbx_pkg::kbx_ent_t         ent
);
    localparam int ROWS = 1 << kbx_pkg::OUT_W;

    kbx_pkg::kbx_ent_t tbl [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        assign tbl[g] = kbx_pkg::kbx_entry(kbx_pkg::OUT_W'(g), ALT_IDX);
    end

    assign ent = tbl[key];
endmodule

// File: rtl/kbx_filter.sv
module kbx_filter #(
    parameter logic [kbx_pkg::IN_W-1:0] ALT_KEY   = 8'h11,
    parameter logic [kbx_pkg::IN_W-1:0] ENTER_KEY = 8'h5A
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      acc,
    input  logic [kbx_pkg::IN_W-1:0]  code,
    input  logic                      make,
    input  kbx_pkg::kbx_ent_t         ent,
    output logic                      push,
    output kbx_pkg::kbx_out_t         out
);
    import kbx_pkg::*;

    kbx_fst_t fst, fst_n;
    logic     blk, blk_n;
    logic     known, is_alt, is_ent;

    assign known  = !code[IN_W-1] && ent.valid;
    assign is_alt = (code == ALT_KEY);
    assign is_ent = (code == ENTER_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            fst <= F_ALT_UP;
            blk <= 1'b0;
        end else begin
            fst <= fst_n;
            blk <= blk_n;
        end
    end

    always_comb begin
        fst_n    = fst;
        blk_n    = blk;
        push     = 1'b0;
        out.make = make;
        out.code = ent.mk;
        if (acc && known) begin
            if (is_alt) begin
                blk_n = 1'b0;
                unique case (fst)
                    F_ALT_UP: if (make) begin
                        push  = 1'b1;
                        fst_n = F_ALT_DOWN;
                    end
                    F_ALT_DOWN: if (!make) begin
                        push     = 1'b1;
                        out.code = ent.bk;
                        fst_n    = F_ALT_UP;
                    end
                endcase
            end else if (is_ent) begin
                if (make) begin
                    push  = !blk;
                    blk_n = 1'b1;
                end
            end else begin
                blk_n = 1'b0;
                if (make) begin
                    push = 1'b1;
                end else if (ent.has_brk) begin
                    push     = 1'b1;
                    out.code = ent.bk;
                end
            end
        end
    end
endmodule

// File: rtl/kbx_fifo.sv
module kbx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full); // R11
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty); // R11
endmodule

// File: rtl/kbx_out.sv
module kbx_out (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      empty,
    input  kbx_pkg::kbx_out_t         head,
    input  logic                      kb_ack,
    output logic                      pop,
    output logic [kbx_pkg::OUT_W-1:0] kb_code,
    output logic                      kb_make,
    output logic                      kb_avail
);
    import kbx_pkg::*;

    kbx_ost_t st, st_n;
    kbx_out_t hold;

    always_ff @(posedge clk) begin
        if (rst) st <= O_IDLE;
        else     st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            O_IDLE:  if (!empty && !kb_ack) st_n = O_SHOW;
            O_SHOW:  if (kb_ack)            st_n = O_GAP;
            O_GAP:   if (!kb_ack)           st_n = O_IDLE;
            default:                        st_n = O_IDLE;
        endcase
    end

    assign pop = (st == O_IDLE) && !empty && !kb_ack;

    always_ff @(posedge clk) begin
        if (rst)      hold <= '0;
        else if (pop) hold <= head;
    end

    always_comb begin
        kb_avail = (st == O_SHOW);
        kb_code  = hold.code;
        kb_make  = hold.make;
    end

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        kb_avail && !kb_ack |=> kb_avail && $stable(kb_code) && $stable(kb_make)); // R9
    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        kb_avail && kb_ack |=> !kb_avail); // R10
    AST_WAIT_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
        !kb_avail && kb_ack |=> !kb_avail); // R10
endmodule

// File: rtl/kbx_translator.sv
module kbx_translator #(
    parameter int                          FIFO_DEPTH = 4,
    parameter logic [kbx_pkg::IN_W-1:0]    ALT_KEY    = 8'h11,
    parameter logic [kbx_pkg::IN_W-1:0]    ENTER_KEY  = 8'h5A,
    parameter logic [kbx_pkg::ID_W-1:0]    IDENT      = 4'b1010
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ev_valid,
    output logic                      ev_ready,
    input  logic [kbx_pkg::IN_W-1:0]  ev_code,
    input  logic                      ev_make,
    output logic [kbx_pkg::OUT_W-1:0] kb_code,
    output logic                      kb_make,
    output logic                      kb_avail,
    input  logic                      kb_ack,
    output logic [kbx_pkg::ID_W-1:0]  kb_ident
);
    import kbx_pkg::*;

    localparam int QW = $bits(kbx_out_t);

    kbx_ent_t ent;
    kbx_out_t f_out, q_head;
    logic     acc, push, pop, empty, full;

    assign kb_ident = IDENT;
    assign ev_ready = !full;
    assign acc      = ev_valid && ev_ready;

    kbx_map #(.ALT_IDX(ALT_KEY[OUT_W-1:0])) u_map (
        .key (ev_code[OUT_W-1:0]),
        .ent (ent)
    );

    kbx_filter #(.ALT_KEY(ALT_KEY), .ENTER_KEY(ENTER_KEY)) u_filter (
        .clk  (clk),
        .rst  (rst),
        .acc  (acc),
        .code (ev_code),
        .make (ev_make),
        .ent  (ent),
        .push (push),
        .out  (f_out)
    );

    kbx_fifo #(.DEPTH(FIFO_DEPTH), .W(QW)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .wr_data (f_out),
        .pop     (pop),
        .rd_data (q_head),
        .empty   (empty),
        .full    (full)
    );

    kbx_out u_out (
        .clk      (clk),
        .rst      (rst),
        .empty    (empty),
        .head     (q_head),
        .kb_ack   (kb_ack),
        .pop      (pop),
        .kb_code  (kb_code),
        .kb_make  (kb_make),
        .kb_avail (kb_avail)
    );
endmodule

// File: tb/kbx_translator_test.sv
`timescale 1ns/1ps
module kbx_translator_test;
    localparam logic [7:0] ALT = 8'h11;
    localparam logic [7:0] ENT = 8'h5A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_valid = 1'b0;
    logic       ev_ready;
    logic [7:0] ev_code = '0;
    logic       ev_make = 1'b0;
    logic [6:0] kb_code;
    logic       kb_make;
    logic       kb_avail;
    logic       kb_ack = 1'b0;
    logic [3:0] kb_ident;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b1;
    bit m_alt = 1'b0;
    bit m_ent = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    kbx_translator uut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_code(ev_code), .ev_make(ev_make), .kb_code(kb_code),
        .kb_make(kb_make), .kb_avail(kb_avail), .kb_ack(kb_ack),
        .kb_ident(kb_ident)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: expectation from the requirement rules, then the handshake
    task automatic send(input logic [7:0] c, input bit mk, input string req);
        bit known, hb, emit;
        logic [6:0] oc;
        known = (c != 8'h00) && (c < 8'h70);
        hb    = ((c >= 8'h20) && (c <= 8'h3F)) || (c == ALT);
        emit  = 1'b0;
        oc    = c[6:0] ^ 7'h55;
        if (known) begin
            if (c == ALT) begin
                m_ent = 1'b0;
                if (mk && !m_alt) begin emit = 1'b1; m_alt = 1'b1; end
                else if (!mk && m_alt) begin emit = 1'b1; oc = c[6:0] ^ 7'h2A; m_alt = 1'b0; end
            end else if (c == ENT) begin
                if (mk) begin emit = !m_ent; m_ent = 1'b1; end
            end else begin
                m_ent = 1'b0;
                if (mk) emit = 1'b1;
                else if (hb) begin emit = 1'b1; oc = c[6:0] ^ 7'h2A; end
            end
        end
        if (emit) begin
            exp_q.push_back({mk, oc});
            tag_q.push_back(req);
        end
        @(negedge clk);
        ev_valid = 1'b1; ev_code = c; ev_make = mk;
        while (!ev_ready) @(negedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (exp_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0 && !kb_avail, req, "queue drained, output quiet",
              exp_q.size() + int'(kb_avail), 0);
    endtask

    // monitor: pops expectations and answers the handshake
    initial begin
        logic [7:0] item;
        string t;
        forever begin
            @(negedge clk);
            if (kb_ack) begin
                check(!kb_avail, "R10", "strobe after ack", int'(kb_avail), 0);
                kb_ack = 1'b0;
            end else if (mon_en && kb_avail) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected code", int'({kb_make, kb_code}), 0);
                end else begin
                    item = exp_q.pop_front();
                    t    = tag_q.pop_front();
                    check({kb_make, kb_code} == item, t, "presented code",
                          int'({kb_make, kb_code}), int'(item));
                end
                kb_ack = 1'b1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!kb_avail, "R1", "strobe after reset", int'(kb_avail), 0);
        check(ev_ready, "R1", "ready after reset", int'(ev_ready), 1);
        check(kb_ident == 4'b1010, "R2", "identifier", int'(kb_ident), 4'hA);

        // R3 plain presses
        send(8'h05, 1'b1, "R3"); send(8'h41, 1'b1, "R3"); send(8'h6F, 1'b1, "R3");
        drain("R3");
        // R4 releases of single-code keys, then a marker
        send(8'h05, 1'b0, "R4"); send(8'h41, 1'b0, "R4");
        drain("R4");
        send(8'h07, 1'b1, "R4");
        drain("R4");
        // R5 releases with their own code
        send(8'h25, 1'b1, "R5"); send(8'h25, 1'b0, "R5"); send(8'h3F, 1'b0, "R5");
        drain("R5");
        // R6 unmapped codes
        send(8'h80, 1'b1, "R6"); send(8'h00, 1'b1, "R6");
        send(8'h75, 1'b1, "R6"); send(8'hFF, 1'b0, "R6");
        drain("R6");
        send(8'h06, 1'b1, "R6");
        drain("R6");
        // R7 Alt chord with repeats and stray release
        send(ALT, 1'b1, "R7"); send(ALT, 1'b1, "R7");
        send(8'h05, 1'b1, "R7"); send(8'h05, 1'b0, "R7");
        send(ALT, 1'b0, "R7"); send(ALT, 1'b0, "R7");
        drain("R7");
        // R8 Enter repeat blocking
        send(ENT, 1'b1, "R8"); send(ENT, 1'b1, "R8"); send(ENT, 1'b1, "R8");
        send(ENT, 1'b0, "R8"); send(ENT, 1'b1, "R8");
        drain("R8");
        send(8'h41, 1'b1, "R8"); send(ENT, 1'b1, "R8");
        send(8'h80, 1'b1, "R8"); send(ENT, 1'b1, "R8");
        drain("R8");
        send(8'h09, 1'b1, "R8");
        drain("R8");
        // R9 / R11 backpressure with terminal not acknowledging
        mon_en = 1'b0;
        for (int i = 1; i <= 5; i++) send(8'(i), 1'b1, "R11");
        @(negedge clk);
        check(!ev_ready, "R11", "ready with full queue", int'(ev_ready), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(kb_avail && kb_code == (7'h01 ^ 7'h55) && kb_make, "R9",
                  "held code without ack", int'({kb_avail, kb_make, kb_code}),
                  int'({2'b11, 7'h54}));
        end
        mon_en = 1'b1;
        drain("R11");
        // R12 reset clears pending codes, Alt and Enter state
        mon_en = 1'b0;
        send(ALT, 1'b1, "R12"); send(ENT, 1'b1, "R12"); send(8'h02, 1'b1, "R12");
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        exp_q.delete(); tag_q.delete(); m_alt = 1'b0; m_ent = 1'b0;
        @(negedge clk);
        check(!kb_avail, "R12", "strobe after reset", int'(kb_avail), 0);
        check(ev_ready, "R12", "ready after reset", int'(ev_ready), 1);
        mon_en = 1'b1;
        send(ALT, 1'b0, "R12");
        drain("R12");
        send(ENT, 1'b1, "R12");
        drain("R12");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule